// File: doc/BRIEF.md
# Chainable Dual Timer/Counter Pair

This block holds two 16-bit timer/counter channels, A and B, behind one word-wide register interface. Each channel has a configuration register, a command register for starting and stopping, a reload register and a readable count. In timer mode a channel advances on every clock. In counter mode it advances once per chosen edge of its own external input, and that input can be inverted and passed through a two-flop synchroniser first. A channel counts up or down, and runs either cyclically (reloading on expiry) or once (stopping on expiry).

Setting the chain bit in channel A's configuration joins the pair into one 32-bit counter. A's settings, commands and reload value then control both halves. Channel B's command register is ignored while the pair is chained, and only A's status bit reports expiry. Each channel has a sticky status bit, cleared by writing one to it, and an enable mask. The interrupt request of a channel is its status bit ANDed with its enable bit.

Top module: `timer_pair`

## Requirements
- R1: After reset every configuration word, count, status bit and interrupt output reads zero.
- R2: A command word (A at address 2, B at address 3) with bit 0 (start) and bit 2 (reload) set loads the count from the reload register and sets the running flag, which reads back as bit 0 of the configuration word. A start without bit 2 resumes from the current count.
- R3: A command with bit 1 (stop) clears the running flag. This takes priority over start. A channel that is not running holds its count.
- R4: A running timer with configuration bit 1 = 0 (down) decrements once per clock. A tick that finds the count at zero is an expiry. With configuration bit 3 = 0 (cyclic), the expiry reloads the count, so the period is reload+1 clocks.
- R5: With configuration bit 1 = 1 (up), the count increments. A tick at all ones is an expiry, which reloads the count in cyclic mode.
- R6: With configuration bit 3 = 1 (one-shot), an expiry sets the count to zero, clears the running flag and the count holds.
- R7: Configuration bit 2 = 1 selects counter mode. Bits 7:6 select the counted edge of the external input: 00 none, 01 rising, 10 falling, 11 both. One edge gives one count.
- R8: Configuration bit 5 inverts the external input before edge detection.
- R9: Configuration bit 8 inserts a two-flop synchroniser, so an input change is counted on the third clock edge instead of the first.
- R10: The status word (address 9) has bit 0 for A and bit 1 for B. Each bit is set by an expiry and cleared by writing 1 to it; writing all ones clears every bit. Output irq[i] is status bit i ANDed with enable bit i (address 8).
- R11: In 16-bit operation only the low 16 bits of the reload register (A at address 4, B at address 5) are loaded into the count.
- R12: With A's configuration bit 4 set, the pair forms one 32-bit counter. The count reads back through A's count address (6) as a full word and reloads from all 32 bits of A's reload register. Only status bit 0 can be raised, and writes to B's command register have no effect.
- R13: Configuration bit 4 does not exist on channel B: it is ignored on write and reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| ext_in | input | 2 | External count inputs, bit 0 for A, bit 1 for B |
| irq | output | 2 | Interrupt requests, bit 0 for A, bit 1 for B |

## Verification
Some properties are checked by assertions on every cycle:
- a channel that is idle holds its count;
- a one-shot expiry drops the running flag;
- a down-count step takes exactly one off the count;
- a status bit rises only after an expiry of its own channel;
- channel B's status never rises while the pair is chained;
- rising-edge selection never yields two counts in a row.

The bench's scenarios are needed for the rest:
- the exact expiry cycle and the value reloaded for random reload values;
- the latency difference that the synchroniser adds;
- inversion together with each edge selection;
- the borrow across the two halves in chained mode;
- the interrupt masking.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [1:0] {
        EDG_NONE = 2'b00,
        EDG_RISE = 2'b01,
        EDG_FALL = 2'b10,
        EDG_BOTH = 2'b11
    } edge_pick_e;

    // Configuration word bits [8:1]; bit 0 is the running flag on read.
    typedef struct packed {
        logic       sync_en;
        edge_pick_e edge_pick;
        logic       invert;
        logic       chain;
        logic       oneshot;
        logic       cnt_mode;
        logic       up;
    } chan_cfg_t;

    localparam int CFG_W  = $bits(chan_cfg_t);
    localparam int CTRL_W = CFG_W + 1;

    typedef struct packed {
        logic reload;
        logic stop;
        logic start;
    } run_cmd_t;

    typedef enum logic [REG_AW-1:0] {
        RA_CFG_A    = 4'd0,
        RA_CFG_B    = 4'd1,
        RA_RUN_A    = 4'd2,
        RA_RUN_B    = 4'd3,
        RA_RELOAD_A = 4'd4,
        RA_RELOAD_B = 4'd5,
        RA_COUNT_A  = 4'd6,
        RA_COUNT_B  = 4'd7,
        RA_IRQ_EN   = 4'd8,
        RA_IRQ_STAT = 4'd9
    } reg_addr_e;

    function automatic logic [CTRL_W-1:0] cfg_word(input chan_cfg_t c, input logic running);
        return {c, running};
    endfunction

endpackage

// File: rtl/tp_edge_unit.sv
module tp_edge_unit
    import timer_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic       invert,
    input  logic       sync_en,
    input  edge_pick_e pick,
    output logic       pulse
);
    logic raw, s1_q, s2_q, prev_q, sample;

    assign raw    = din ^ invert;
    assign sample = sync_en ? s2_q : raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= raw;
            s2_q   <= s1_q;
            prev_q <= sample;
        end
    end

    always_comb begin
        unique case (pick)
            EDG_RISE: pulse = sample & ~prev_q;
            EDG_FALL: pulse = ~sample & prev_q;
            EDG_BOTH: pulse = sample ^ prev_q;
            default:  pulse = 1'b0;
        endcase
    end

    // R7: a rising-only selection cannot produce pulses on two adjacent cycles
    a_r7_rise_not_adjacent: assert property (@(posedge clk) disable iff (rst)
        (pulse && pick == EDG_RISE) |=> (!pulse || !$stable({pick, invert, sync_en})));

endmodule

// File: rtl/tp_channel.sv
module tp_channel
    import timer_pair_pkg::*;
#(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         carry_ok,
    input  logic         upper_term,
    input  logic         slave,
    input  logic         master_run,
    input  logic         up,
    input  logic         oneshot,
    input  logic         cmd_valid,
    input  run_cmd_t     cmd,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         running,
    output logic         term,
    output logic         expire
);
    logic         en_q;
    logic [W-1:0] cnt_q;
    logic         cmd_hit, step;

    assign running = slave ? master_run : en_q;
    assign cmd_hit = cmd_valid && (cmd.stop || cmd.start);
    assign term    = up ? (&cnt_q) : (cnt_q == '0);
    assign step    = running && tick && carry_ok && !cmd_hit;
    assign expire  = step && term && upper_term;
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else if (cmd_hit) begin
            if (cmd.stop) begin
                en_q <= 1'b0;
            end else begin
                en_q <= 1'b1;
                if (cmd.reload) cnt_q <= reload_val;
            end
        end else if (step) begin
            if (term && upper_term) begin
                if (oneshot) begin
                    cnt_q <= '0;
                    en_q  <= 1'b0;
                end else begin
                    cnt_q <= reload_val;
                end
            end else if (up) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R3: an idle channel with no command keeps its count
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd_hit) |=> $stable(count));

    // R6: a one-shot expiry leaves the channel stopped
    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (expire && oneshot) |=> !running);

    // R4: a non-terminal down step removes exactly one
    a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
        (step && !up && !term) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/timer_pair.sv
module timer_pair
    import timer_pair_pkg::*;
#(
    parameter int HALF_W = 16
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [2*HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0]   rdata,
    input  logic [1:0]            ext_in,
    output logic [1:0]            irq
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int NCH    = 2;

    chan_cfg_t           cfg_q    [NCH];
    logic [FULL_W-1:0]   reload_a_q;
    logic [HALF_W-1:0]   reload_b_q;
    logic [NCH-1:0]      irq_en_q, irq_stat_q;

    logic                chained;
    logic [NCH-1:0]      run_wr, pulse, tick_raw;
    logic [HALF_W-1:0]   cnt_s    [NCH];
    logic [NCH-1:0]      run_s, term_s, evt_s;

    logic [NCH-1:0]      ch_tick, ch_carry, ch_upper, ch_slave, ch_up, ch_once, ch_cmdv;
    logic [HALF_W-1:0]   ch_reload [NCH];
    logic [NCH-1:0]      stat_set, stat_clr;

    assign chained   = cfg_q[0].chain;
    assign run_wr[0] = wr_en && (addr == RA_RUN_A);
    assign run_wr[1] = wr_en && (addr == RA_RUN_B);

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q[0]   <= '0;
            cfg_q[1]   <= '0;
            reload_a_q <= '0;
            reload_b_q <= '0;
            irq_en_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CFG_A:    cfg_q[0] <= chan_cfg_t'(wdata[CFG_W:1]);
                RA_CFG_B: begin
                    cfg_q[1]       <= chan_cfg_t'(wdata[CFG_W:1]);
                    cfg_q[1].chain <= 1'b0;
                end
                RA_RELOAD_A: reload_a_q <= wdata;
                RA_RELOAD_B: reload_b_q <= wdata[HALF_W-1:0];
                RA_IRQ_EN:   irq_en_q   <= wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    // Input conditioning per channel
    for (genvar i = 0; i < NCH; i++) begin : g_edge
        tp_edge_unit u_edge (
            .clk     (clk),
            .rst     (rst),
            .din     (ext_in[i]),
            .invert  (cfg_q[i].invert),
            .sync_en (cfg_q[i].sync_en),
            .pick    (cfg_q[i].edge_pick),
            .pulse   (pulse[i])
        );
        assign tick_raw[i] = cfg_q[i].cnt_mode ? pulse[i] : 1'b1;
    end

    // Role selection: B becomes the upper half of A when chained
    always_comb begin
        ch_tick[0]   = tick_raw[0];
        ch_carry[0]  = 1'b1;
        ch_upper[0]  = chained ? term_s[1] : 1'b1;
        ch_slave[0]  = 1'b0;
        ch_up[0]     = cfg_q[0].up;
        ch_once[0]   = cfg_q[0].oneshot;
        ch_cmdv[0]   = run_wr[0];
        ch_reload[0] = reload_a_q[HALF_W-1:0];

        ch_tick[1]   = chained ? tick_raw[0] : tick_raw[1];
        ch_carry[1]  = chained ? term_s[0] : 1'b1;
        ch_upper[1]  = 1'b1;
        ch_slave[1]  = chained;
        ch_up[1]     = chained ? cfg_q[0].up : cfg_q[1].up;
        ch_once[1]   = chained ? cfg_q[0].oneshot : cfg_q[1].oneshot;
        ch_cmdv[1]   = chained ? run_wr[0] : run_wr[1];
        ch_reload[1] = chained ? reload_a_q[FULL_W-1:HALF_W] : reload_b_q;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tp_channel #(.W(HALF_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .tick       (ch_tick[i]),
            .carry_ok   (ch_carry[i]),
            .upper_term (ch_upper[i]),
            .slave      (ch_slave[i]),
            .master_run (run_s[0]),
            .up         (ch_up[i]),
            .oneshot    (ch_once[i]),
            .cmd_valid  (ch_cmdv[i]),
            .cmd        (run_cmd_t'(wdata[2:0])),
            .reload_val (ch_reload[i]),
            .count      (cnt_s[i]),
            .running    (run_s[i]),
            .term       (term_s[i]),
            .expire     (evt_s[i])
        );
    end

    // Status: set wins over a same-cycle clear
    always_comb begin
        stat_set    = evt_s;
        stat_set[1] = evt_s[1] && !chained;
        stat_clr    = (wr_en && addr == RA_IRQ_STAT) ? wdata[NCH-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_stat_q <= '0;
        else     irq_stat_q <= stat_set | (irq_stat_q & ~stat_clr);
    end

    assign irq = irq_stat_q & irq_en_q;

    // Read mux
    always_comb begin
        rdata = '0;
        case (addr)
            RA_CFG_A:    rdata[CTRL_W-1:0] = cfg_word(cfg_q[0], run_s[0]);
            RA_CFG_B:    rdata[CTRL_W-1:0] = cfg_word(cfg_q[1], run_s[1]);
            RA_RELOAD_A: rdata = reload_a_q;
            RA_RELOAD_B: rdata[HALF_W-1:0] = reload_b_q;
            RA_COUNT_A:  rdata = chained ? {cnt_s[1], cnt_s[0]} : {{HALF_W{1'b0}}, cnt_s[0]};
            RA_COUNT_B:  rdata[HALF_W-1:0] = cnt_s[1];
            RA_IRQ_EN:   rdata[NCH-1:0] = irq_en_q;
            RA_IRQ_STAT: rdata[NCH-1:0] = irq_stat_q;
            default:     rdata = '0;
        endcase
    end

    // R10: status of A rises only after an expiry of A
    a_r10_stat_needs_expiry: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_stat_q[0]) |-> $past(evt_s[0]));

    // R12: B's status cannot rise while the pair is chained
    a_r12_chain_mutes_b: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_stat_q[1]) |-> !$past(chained));

endmodule

// File: tb/tb_timer_pair.sv
module tb_timer_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  ext_in = '0;
    logic [1:0]  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [3:0] A_CFG_A = 4'd0, A_CFG_B = 4'd1, A_RUN_A = 4'd2, A_RUN_B = 4'd3,
                           A_REL_A = 4'd4, A_REL_B = 4'd5, A_CNT_A = 4'd6, A_CNT_B = 4'd7,
                           A_IEN = 4'd8, A_IST = 4'd9;
    localparam logic [31:0] GO_RL = 32'h5, GO = 32'h1, HALT = 32'h2;

    timer_pair dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_in(ext_in), .irq(irq)
    );

    always #4 clk = ~clk;

    // All bench actions start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic chk_run(input string tag, input logic [3:0] a, input logic exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, {31'd0, v[0]}, {31'd0, exp});
    endtask

    function automatic logic [31:0] exp_count(input bit up, input int r, input int k);
        int p;
        p = up ? (65536 - r) : (r + 1);
        return up ? 32'(r + (k % p)) : 32'(r - (k % p));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired, all requirements got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1357));
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1 reset state
        chk_reg("R1 cfg A", A_CFG_A, 0);
        chk_reg("R1 cfg B", A_CFG_B, 0);
        chk_reg("R1 count A", A_CNT_A, 0);
        chk_reg("R1 status", A_IST, 0);
        chk("R1 irq", {30'd0, irq}, 0);

        // R13 chain bit absent on B
        wr(A_CFG_B, 32'h10);
        chk_reg("R13 cfg B bit4", A_CFG_B, 0);

        // R2/R4 down cyclic timer, reload 5
        wr(A_IEN, 32'h3);
        wr(A_CFG_A, 32'h0);
        wr(A_REL_A, 32'd5);
        wr(A_RUN_A, GO_RL);
        chk_reg("R2 load on start", A_CNT_A, 5);
        chk_run("R2 running flag", A_CFG_A, 1'b1);
        wait_n(3);
        chk_reg("R4 down step", A_CNT_A, 2);
        // R3 stop
        wr(A_RUN_A, HALT);
        chk_reg("R3 stop holds", A_CNT_A, 2);
        chk_run("R3 flag cleared", A_CFG_A, 1'b0);
        wait_n(4);
        chk_reg("R3 idle holds", A_CNT_A, 2);
        // R2 resume
        wr(A_RUN_A, GO);
        chk_reg("R2 resume keeps count", A_CNT_A, 2);
        wait_n(2);
        chk_reg("R4 reaches zero", A_CNT_A, 0);
        chk_reg("R4 no expiry yet", A_IST, 0);
        wait_n(1);
        chk_reg("R4 cyclic reload", A_CNT_A, 5);
        chk_reg("R10 status A set", A_IST, 1);
        chk("R10 irq A", {30'd0, irq}, 1);
        // R10 write-one-to-clear
        wr(A_IST, 32'h2);
        chk_reg("R10 other bit kept", A_IST, 1);
        wr(A_IST, 32'h1);
        chk_reg("R10 cleared", A_IST, 0);
        wr(A_RUN_A, HALT);

        // R6 one-shot down
        wr(A_CFG_A, 32'h08);
        wr(A_REL_A, 32'd3);
        wr(A_RUN_A, GO_RL);
        wait_n(4);
        chk_reg("R6 count zero", A_CNT_A, 0);
        chk_run("R6 stopped", A_CFG_A, 1'b0);
        chk_reg("R6 status", A_IST, 1);
        wait_n(3);
        chk_reg("R6 holds", A_CNT_A, 0);
        wr(A_IST, 32'h3);

        // R5 up cyclic
        wr(A_CFG_A, 32'h02);
        wr(A_REL_A, 32'h0000FFFC);
        wr(A_RUN_A, GO_RL);
        wait_n(3);
        chk_reg("R5 reaches ones", A_CNT_A, 32'hFFFF);
        chk_reg("R5 no expiry yet", A_IST, 0);
        wait_n(1);
        chk_reg("R5 cyclic reload", A_CNT_A, 32'hFFFC);
        chk_reg("R5 status", A_IST, 1);
        wr(A_RUN_A, HALT);
        wr(A_IST, 32'h3);

        // R11 only low half of reload in 16-bit mode
        wr(A_CFG_A, 32'h0);
        wr(A_REL_A, 32'h00012345);
        wr(A_RUN_A, GO_RL);
        chk_reg("R11 low half loaded", A_CNT_A, 32'h2345);
        wr(A_RUN_A, HALT);

        // R7 counter mode on B: up, rising edges
        wr(A_CFG_B, 32'h46);
        wait_n(2);
        wr(A_REL_B, 32'd0);
        wr(A_RUN_B, GO_RL);
        ext_in[1] = 1'b1; wait_n(2);
        chk_reg("R7 rising counted", A_CNT_B, 1);
        ext_in[1] = 1'b0; wait_n(2);
        chk_reg("R7 falling ignored", A_CNT_B, 1);
        wr(A_CFG_B, 32'hC6);
        ext_in[1] = 1'b1; wait_n(2);
        ext_in[1] = 1'b0; wait_n(2);
        chk_reg("R7 both edges", A_CNT_B, 3);
        wr(A_CFG_B, 32'h06);
        ext_in[1] = 1'b1; wait_n(2);
        ext_in[1] = 1'b0; wait_n(2);
        chk_reg("R7 no edge selected", A_CNT_B, 3);
        wr(A_CFG_B, 32'h86);
        ext_in[1] = 1'b1; wait_n(2);
        chk_reg("R7 fall sel ignores rise", A_CNT_B, 3);
        ext_in[1] = 1'b0; wait_n(2);
        chk_reg("R7 fall sel counts fall", A_CNT_B, 4);

        // R8 inversion with rising selection
        wr(A_RUN_B, HALT);
        wr(A_CFG_B, 32'h66);
        wait_n(2);
        wr(A_RUN_B, GO);
        chk_reg("R8 no count while stopped", A_CNT_B, 4);
        ext_in[1] = 1'b1; wait_n(2);
        chk_reg("R8 inverted rise ignored", A_CNT_B, 4);
        ext_in[1] = 1'b0; wait_n(2);
        chk_reg("R8 inverted fall counted", A_CNT_B, 5);

        // R9 synchroniser latency
        wr(A_RUN_B, HALT);
        wr(A_CFG_B, 32'h146);
        wait_n(4);
        wr(A_RUN_B, GO);
        ext_in[1] = 1'b1; wait_n(2);
        chk_reg("R9 not yet counted", A_CNT_B, 5);
        wait_n(1);
        chk_reg("R9 counted on third edge", A_CNT_B, 6);
        wr(A_RUN_B, HALT);

        // R10 status index of B and clear-all
        wr(A_IST, 32'h3);
        wr(A_CFG_B, 32'h08);
        wr(A_REL_B, 32'd1);
        wr(A_RUN_B, GO_RL);
        wait_n(1);
        chk_reg("R10 B not yet", A_IST, 0);
        wait_n(1);
        chk_reg("R10 B bit1", A_IST, 2);
        chk("R10 irq B", {30'd0, irq}, 2);
        wr(A_IST, 32'hFFFFFFFF);
        chk_reg("R10 clear all", A_IST, 0);

        // R10 masking
        wr(A_IEN, 32'h2);
        wr(A_CFG_A, 32'h08);
        wr(A_REL_A, 32'd0);
        wr(A_RUN_A, GO_RL);
        wait_n(1);
        chk_reg("R10 masked status set", A_IST, 1);
        chk("R10 masked irq low", {30'd0, irq}, 0);
        wr(A_IST, 32'h3);
        wr(A_IEN, 32'h3);

        // R12 chained 32-bit down cyclic
        wr(A_CFG_A, 32'h10);
        wr(A_REL_A, 32'h00010001);
        wr(A_RUN_A, GO_RL);
        chk_reg("R12 full reload", A_CNT_A, 32'h00010001);
        wait_n(2);
        chk_reg("R12 borrow across halves", A_CNT_A, 32'h0000FFFF);
        wr(A_RUN_B, HALT);
        chk_reg("R12 B command ignored", A_CNT_A, 32'h0000FFFE);
        chk_run("R12 still running", A_CFG_A, 1'b1);
        wait_n(1);
        chk_reg("R12 keeps counting", A_CNT_A, 32'h0000FFFD);
        wait_n(65533);
        chk_reg("R12 at zero", A_CNT_A, 0);
        chk_reg("R12 no expiry yet", A_IST, 0);
        wait_n(1);
        chk_reg("R12 reload 32-bit", A_CNT_A, 32'h00010001);
        chk_reg("R12 only A status", A_IST, 1);
        wr(A_RUN_A, HALT);
        wr(A_CFG_A, 32'h0);

        // R4/R5 random cyclic timers against a model
        for (int it = 0; it < 24; it++) begin
            bit up;
            int r, k;
            up = $urandom_range(0, 1) == 1;
            r  = up ? (65535 - $urandom_range(0, 40)) : $urandom_range(0, 40);
            k  = $urandom_range(0, 3 * 41);
            wr(A_RUN_A, HALT);
            wr(A_IST, 32'h3);
            wr(A_CFG_A, up ? 32'h02 : 32'h00);
            wr(A_REL_A, {16'($urandom), 16'(r)});
            wr(A_RUN_A, GO_RL);
            wait_n(k);
            rd(A_CNT_A, v);
            chk(up ? "R5 random count" : "R4 random count", v, exp_count(up, r, k));
            rd(A_IST, v);
            chk(up ? "R5 random status" : "R4 random status", v,
                {31'd0, k >= (up ? 65536 - r : r + 1)});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule